// File: doc/BRIEF.md
# Sequenced 1/12/19 Floating-Point Adder

This block adds two 32-bit floating-point words laid out as one sign bit (bit 31), a 12-bit biased exponent (bits 30:19) and a 19-bit fraction (bits 18:0). Every operand with a nonzero exponent carries a hidden leading one. An exponent field of zero marks the operand as zero, whatever its fraction holds. The result uses the same layout. Two range flags come with it: one for a result too large to encode and one for a result too small to encode.

The work is spread over a short state sequence. `ST_IDLE` waits for `start` and captures both words. `ST_ALIGN` orders the operands by exponent, right-shifts the smaller significand into a 32-bit working field and folds the shifted-out bits into a sticky bit. The same state two's-complements each negative significand. `ST_ADD` forms one signed sum. `ST_NORM` takes the magnitude, shifts the leading one back to the hidden position, rounds to nearest-even and checks the exponent range. `ST_DONE` raises `done` for one cycle. The transitions are: `ST_IDLE`→`ST_ALIGN` on `start`, then `ST_ALIGN`→`ST_ADD`→`ST_NORM`→`ST_DONE`→`ST_IDLE` unconditionally.

A caller pulses `start` with both operands valid. It then waits for `done` and reads `sum` and the flags. These stay unchanged until the next operation reaches `ST_NORM`.

Top module: `fpa_adder`

## Requirements
- R1: With both operands normal, `sum` is the correctly rounded sum. Its sign is bit 31, its exponent is in bits 30:19, and its fraction is in bits 18:0 with an implied leading one.
- R2: An operand whose exponent field is zero acts as exact zero, whatever its sign and fraction.
- R3: An exactly cancelling sum yields `sum` = 0 with `flag_unf` = 0 and `flag_ovf` = 0.
- R4: The result sign is the sign of the exact sum. After cancellation the result is renormalized, and its exponent drops by the number of leading zeros removed.
- R5: Rounding is to nearest with ties to even, and it counts every bit shifted out during alignment, including operands far below the other.
- R6: When rounding carries out of the significand, the fraction becomes zero and the exponent rises by one.
- R7: If the final exponent exceeds 4095, then `flag_ovf` = 1, `flag_unf` = 0, and `sum` = {result sign, twelve ones, nineteen ones}.
- R8: If the final exponent falls below 1, then `flag_unf` = 1, `flag_ovf` = 0, and `sum` = 0.
- R9: `start` is accepted only in `ST_IDLE`, and is ignored at any other time. `done` is high for exactly one cycle. That cycle follows the third rising edge after the edge that accepted `start`.
- R10: Reset clears `sum`, both flags and `done`. Outside reset, `sum` and the flags change only when an operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an addition of `op_a` and `op_b` |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| done | output | 1 | One-cycle pulse when the result is ready |
| sum | output | 32 | Result word, held between operations |
| flag_unf | output | 1 | Result exponent below the smallest encodable |
| flag_ovf | output | 1 | Result exponent above the largest encodable |

## Verification
The assertions assume that every operand with a nonzero exponent is normalized. They also assume that `start` is a single-cycle pulse whose operands are steady on the accepting edge. The normalization check further relies on the working field never carrying past its headroom bit, which holds for any pair of 20-bit significands.

The stimulus uses only exponent/fraction pairs built field by field. It drives `start` for exactly one cycle per operation. Its only mid-operation `start` pulses are the deliberate ones that test R9.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Sequencer states of the adder
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_DONE
    } fpa_state_e;

    localparam int FPA_FRAC_W = 19;
    localparam int FPA_EXP_W  = 12;
    localparam int FPA_GRD_W  = 10;

endpackage

// File: rtl/fpa_align.sv
module fpa_align #(
    parameter int FRAC_W = fpa_pkg::FPA_FRAC_W,
    parameter int EXP_W  = fpa_pkg::FPA_EXP_W,
    parameter int GRD_W  = fpa_pkg::FPA_GRD_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int ACC_W  = FRAC_W + GRD_W + 3
) (
    input  logic [WORD_W-1:0] op_x,
    input  logic [WORD_W-1:0] op_y,
    output logic [ACC_W-1:0]  acc_big,
    output logic [ACC_W-1:0]  acc_sml,
    output logic [EXP_W-1:0]  exp_big
);

    // Working significand: two headroom bits, hidden one, fraction, guard bits
    function automatic logic [ACC_W-1:0] sig_of(input logic [WORD_W-1:0] w);
        if (w[WORD_W-2 -: EXP_W] == '0)
            return '0;
        return {2'b00, 1'b1, w[FRAC_W-1:0], {GRD_W{1'b0}}};
    endfunction

    logic [EXP_W-1:0]  ex, ey, exp_sml, diff;
    logic              swap, sticky;
    logic [WORD_W-1:0] big_w, sml_w;
    logic [ACC_W-1:0]  sml_raw, lost_mask;
    logic [ACC_W-1:0]  mag  [2];
    logic              sgn  [2];
    logic [ACC_W-1:0]  conv [2];

    assign ex      = op_x[WORD_W-2 -: EXP_W];
    assign ey      = op_y[WORD_W-2 -: EXP_W];
    assign swap    = (ey > ex);
    assign big_w   = swap ? op_y : op_x;
    assign sml_w   = swap ? op_x : op_y;
    assign exp_big = swap ? ey : ex;
    assign exp_sml = swap ? ex : ey;
    assign diff    = exp_big - exp_sml;

    // Right shift of the smaller operand, shifted-out bits kept as sticky
    assign sml_raw   = sig_of(sml_w);
    assign lost_mask = ~({ACC_W{1'b1}} << diff);
    assign sticky    = |(sml_raw & lost_mask);

    assign mag[0] = sig_of(big_w);
    assign mag[1] = (sml_raw >> diff) | {{(ACC_W-1){1'b0}}, sticky};
    assign sgn[0] = big_w[WORD_W-1];
    assign sgn[1] = sml_w[WORD_W-1];

    // Sign check: negative significands become two's complement
    for (genvar g = 0; g < 2; g++) begin : g_sign
        assign conv[g] = sgn[g] ? (~mag[g] + 1'b1) : mag[g];
    end

    assign acc_big = conv[0];
    assign acc_sml = conv[1];

endmodule

// File: rtl/fpa_normround.sv
module fpa_normround #(
    parameter int FRAC_W = fpa_pkg::FPA_FRAC_W,
    parameter int EXP_W  = fpa_pkg::FPA_EXP_W,
    parameter int GRD_W  = fpa_pkg::FPA_GRD_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int ACC_W  = FRAC_W + GRD_W + 3,
    localparam int LW     = $clog2(ACC_W),
    localparam int HID    = FRAC_W + GRD_W,
    localparam int EMAX   = (1 << EXP_W) - 1
) (
    input  logic [ACC_W-1:0]  acc_sum,
    input  logic [EXP_W-1:0]  exp_in,
    output logic [WORD_W-1:0] res,
    output logic              unf,
    output logic              ovf
);

    logic              neg, guard, sticky, up, carry;
    logic [ACC_W-1:0]  mag, norm;
    logic [LW-1:0]     lead;
    logic [FRAC_W:0]   keep;
    logic [FRAC_W+1:0] rsum;
    logic [FRAC_W-1:0] frac;
    int                e_norm, e_fin;

    always_comb begin
        neg = acc_sum[ACC_W-1];
        mag = neg ? (~acc_sum + 1'b1) : acc_sum;

        // Leading-one search
        lead = '0;
        for (int i = 0; i < ACC_W; i++) begin
            if (mag[i]) lead = LW'(i);
        end

        // Bring the leading one to the hidden position
        if (int'(lead) > HID) begin
            norm = (mag >> 1) | {{(ACC_W-1){1'b0}}, mag[0]};
        end else begin
            norm = mag << (HID - int'(lead));
        end
        e_norm = int'(exp_in) + int'(lead) - HID;

        // Round to nearest, ties to even
        keep   = norm[HID -: FRAC_W+1];
        guard  = norm[GRD_W-1];
        sticky = |norm[GRD_W-2:0];
        up     = guard & (sticky | keep[0]);
        rsum   = {1'b0, keep} + (FRAC_W+2)'(up);
        carry  = rsum[FRAC_W+1];
        frac   = carry ? rsum[FRAC_W:1] : rsum[FRAC_W-1:0];
        e_fin  = e_norm + (carry ? 1 : 0);

        // Range check and packing
        res = '0;
        unf = 1'b0;
        ovf = 1'b0;
        if (mag != '0) begin
            if (e_fin > EMAX) begin
                ovf = 1'b1;
                res = {neg, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
            end else if (e_fin < 1) begin
                unf = 1'b1;
            end else begin
                res = {neg, e_fin[EXP_W-1:0], frac};
            end
        end
    end

    always_comb begin
        if (mag != '0) begin
            AST_NORM_LEAD: assert (norm[HID]) else $error("normalized significand lost its leading one"); // R4
        end
    end

endmodule

// File: rtl/fpa_adder.sv
module fpa_adder #(
    parameter int FRAC_W = fpa_pkg::FPA_FRAC_W,
    parameter int EXP_W  = fpa_pkg::FPA_EXP_W,
    parameter int GRD_W  = fpa_pkg::FPA_GRD_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int ACC_W  = FRAC_W + GRD_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              done,
    output logic [WORD_W-1:0] sum,
    output logic              flag_unf,
    output logic              flag_ovf
);
    import fpa_pkg::*;

    fpa_state_e state_q, state_d;

    logic [WORD_W-1:0] opa_q, opb_q, sum_q;
    logic [ACC_W-1:0]  accb_q, accs_q, accsum_q;
    logic [EXP_W-1:0]  expb_q;
    logic              unf_q, ovf_q;

    logic [ACC_W-1:0]  al_big, al_sml;
    logic [EXP_W-1:0]  al_exp;
    logic [WORD_W-1:0] nr_res;
    logic              nr_unf, nr_ovf;

    fpa_align #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .GRD_W(GRD_W)) u_align (
        .op_x    (opa_q),
        .op_y    (opb_q),
        .acc_big (al_big),
        .acc_sml (al_sml),
        .exp_big (al_exp)
    );

    fpa_normround #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .GRD_W(GRD_W)) u_norm (
        .acc_sum (accsum_q),
        .exp_in  (expb_q),
        .res     (nr_res),
        .unf     (nr_unf),
        .ovf     (nr_ovf)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ALIGN;
            ST_ALIGN: state_d = ST_ADD;
            ST_ADD:   state_d = ST_NORM;
            ST_NORM:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q    <= '0;
            opb_q    <= '0;
            accb_q   <= '0;
            accs_q   <= '0;
            accsum_q <= '0;
            expb_q   <= '0;
            sum_q    <= '0;
            unf_q    <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        opa_q <= op_a;
                        opb_q <= op_b;
                    end
                end
                ST_ALIGN: begin
                    accb_q <= al_big;
                    accs_q <= al_sml;
                    expb_q <= al_exp;
                end
                ST_ADD: begin
                    accsum_q <= accb_q + accs_q;
                end
                ST_NORM: begin
                    sum_q <= nr_res;
                    unf_q <= nr_unf;
                    ovf_q <= nr_ovf;
                end
                default: ;
            endcase
        end
    end

    assign done     = (state_q == ST_DONE);
    assign sum      = sum_q;
    assign flag_unf = unf_q;
    assign flag_ovf = ovf_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done longer than one cycle"); // R9
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(start && state_q == ST_IDLE, 4)) else $error("done without accepted start four edges earlier"); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(flag_unf && flag_ovf)) else $error("both range flags set"); // R7
    AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) flag_unf |-> (sum == '0)) else $error("underflow result not zero"); // R8
    AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n) flag_ovf |-> (sum[WORD_W-2:0] == '1)) else $error("overflow result not saturated"); // R7

endmodule

// File: tb/fpa_adder_tb.sv
`timescale 1ns/1ps
module fpa_adder_tb;

    function automatic logic [31:0] mk(input logic s, input int e, input int f);
        return {s, e[11:0], f[18:0]};
    endfunction

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic        u;
        logic        o;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{"R1", mk(0,2047,0),       mk(0,2047,0),       mk(0,2048,0),        1'b0, 1'b0}, // 1+1
        '{"R1", mk(0,2047,'h40000), mk(0,2047,0),       mk(0,2048,'h20000),  1'b0, 1'b0}, // 1.5+1
        '{"R4", mk(0,2048,'h40000), mk(1,2047,0),       mk(0,2048,0),        1'b0, 1'b0}, // 3-1
        '{"R4", mk(0,2047,0),       mk(1,2047,'h40000), mk(1,2046,0),        1'b0, 1'b0}, // 1-1.5
        '{"R4", mk(1,2048,0),       mk(0,2047,0),       mk(1,2047,0),        1'b0, 1'b0}, // -2+1
        '{"R4", mk(0,2047,1),       mk(1,2047,0),       mk(0,2028,0),        1'b0, 1'b0}, // deep cancel
        '{"R2", mk(0,0,'h12345),    mk(1,100,'h05555),  mk(1,100,'h05555),   1'b0, 1'b0},
        '{"R2", mk(0,0,0),          mk(1,0,5),          32'h0,               1'b0, 1'b0},
        '{"R3", mk(0,2047,0),       mk(1,2047,0),       32'h0,               1'b0, 1'b0},
        '{"R5", mk(0,2047,0),       mk(0,2027,0),       mk(0,2047,0),        1'b0, 1'b0}, // tie, even down
        '{"R5", mk(0,2047,1),       mk(0,2027,0),       mk(0,2047,2),        1'b0, 1'b0}, // tie, odd up
        '{"R5", mk(0,2047,0),       mk(0,2027,1),       mk(0,2047,1),        1'b0, 1'b0}, // above half
        '{"R5", mk(0,2047,0),       mk(0,100,0),        mk(0,2047,0),        1'b0, 1'b0}, // far positive
        '{"R5", mk(0,2047,0),       mk(1,100,0),        mk(0,2047,0),        1'b0, 1'b0}, // far negative
        '{"R6", mk(0,2047,'h7FFFF), mk(0,2027,0),       mk(0,2048,0),        1'b0, 1'b0},
        '{"R7", mk(0,4095,0),       mk(0,4095,0),       mk(0,4095,'h7FFFF),  1'b0, 1'b1},
        '{"R7", mk(1,4095,0),       mk(1,4095,0),       mk(1,4095,'h7FFFF),  1'b0, 1'b1},
        '{"R7", mk(0,4095,'h7FFFF), mk(0,4075,0),       mk(0,4095,'h7FFFF),  1'b0, 1'b1}, // R6 carry into O
        '{"R8", mk(0,1,'h40000),    mk(1,1,0),          32'h0,               1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        done;
    logic [31:0] sum;
    logic        flag_unf, flag_ovf;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    fpa_adder u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_a     (op_a),
        .op_b     (op_b),
        .done     (done),
        .sum      (sum),
        .flag_unf (flag_unf),
        .flag_ovf (flag_ovf)
    );

    task automatic chk(input logic [23:0] tag, input logic [33:0] act, input logic [33:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          output logic [33:0] res, output int lat);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        res = {sum, flag_unf, flag_ovf};
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [33:0] r, held;
        int lat;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", {sum, flag_unf, flag_ovf}, 34'h0);
        chk("R10", {33'h0, done}, 34'h0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].a, VECS[i].b, r, lat);
            chk(VECS[i].tag, r, {VECS[i].r, VECS[i].u, VECS[i].o});
        end

        // R9: latency and single-cycle done
        run_op(mk(0,2047,0), mk(0,2047,0), r, lat);
        chk("R9", 34'(lat), 34'd3);
        @(negedge clk);
        chk("R9", {33'h0, done}, 34'h0);

        // R10: result held while idle, and while the next operation runs
        held = {sum, flag_unf, flag_ovf};
        repeat (5) @(negedge clk);
        chk("R10", {sum, flag_unf, flag_ovf}, held);
        op_a = mk(0,4095,0); op_b = mk(0,4095,0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10", {sum, flag_unf, flag_ovf}, held);
        while (!done) @(negedge clk);
        chk("R7", {sum, flag_unf, flag_ovf}, {mk(0,4095,'h7FFFF), 1'b0, 1'b1});

        // R9: start while busy is ignored
        @(negedge clk);
        op_a = mk(0,2047,0); op_b = mk(0,2047,0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op_a = mk(0,2048,'h40000); op_b = mk(0,2048,'h40000); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk("R9", {sum, flag_unf, flag_ovf}, {mk(0,2048,0), 2'b00});
        begin : no_second
            int extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R9", 34'(extra), 34'd0);
        end

        // R10: reset during an operation clears everything
        op_a = mk(0,2047,0); op_b = mk(0,2047,0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", {sum, flag_unf, flag_ovf}, 34'h0);
        rst_n = 1'b1;
        begin : no_done_after_reset
            int seen = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk("R10", 34'(seen), 34'd0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule